// File: doc/BRIEF.md
# Transmit Descriptor Poll Scheduler

This block decides when the transmit path should look at its descriptor ring for a new frame. An interval timer counts down a programmable number of clock ticks. When it reaches zero, the block raises a one-cycle poll request. Software can turn the periodic poll off, so that only its own demand strobe starts a poll. A demand strobe always asks for one poll straight away. No request of either kind leaves the block while the transmitter is reported off.

Each request sets a busy flag. The flag stays up until the fetch logic acknowledges the request. While busy is up, demands are folded into the outstanding poll, so at most one request is in flight. Every issued poll, periodic or demanded, reloads the interval timer. A demanded poll therefore pushes the next periodic poll a full interval out.

A hard reset (asynchronous) and a soft reset (synchronous) both restore the configuration defaults and clear the timer. The stop input leaves the configuration and the timer alone. It only discards a demand that has not yet been issued.

Top module: `txpoll_sched`

## Requirements
- R1: With periodic polling enabled, the transmitter on and each request acknowledged in its own cycle, requests repeat every interval+1 clock cycles. Here interval is the programmed reload count.
- R2: While the stored poll-disable bit is 1, no periodic request is issued.
- R3: A demand strobe sampled while the transmitter is on and no request is outstanding produces poll_req in the very next cycle. This holds whether the poll-disable bit is 0 or 1.
- R4: poll_req is never high unless tx_on was high at the preceding clock edge. A demand that arrives while tx_on is low stays pending and is issued one cycle after tx_on is sampled high.
- R5: poll_req is high for exactly one cycle. poll_busy rises with it and stays high until poll_ack is sampled high. No new request is issued while poll_busy is high.
- R6: A demand that arrives while a request is outstanding is merged into that request. The pending demand clears when the acknowledge is accepted, and no second request follows for it.
- R7: Any issued poll, demanded or periodic, reloads the timer. After a demanded poll, the next periodic request comes interval+1 cycles later.
- R8: Hard reset (rst_n low) and soft reset (soft_rst high at an edge) clear the poll-disable bit, clear the timer to zero and load the interval with RST_INTERVAL. With tx_on high, the first request therefore appears one cycle after reset ends, and the next one RST_INTERVAL+1 cycles after that.
- R9: A stop pulse changes neither the poll-disable bit, the interval nor the running timer count. It discards a demand that is pending and not yet issued.
- R10: cfg_wr loads cfg_poll_dis and cfg_interval together at one edge. The new interval is used from the next timer reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop | input | 1 | Stop pulse; drops a pending, unissued demand |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_poll_dis | input | 1 | Poll-disable value loaded by cfg_wr (1 = periodic polling off) |
| cfg_interval | input | CNT_W | Interval reload count loaded by cfg_wr |
| tx_demand | input | 1 | Transmit-demand strobe |
| tx_on | input | 1 | Transmitter-on status |
| poll_ack | input | 1 | Acknowledge from the descriptor fetch logic |
| poll_req | output | 1 | One-cycle poll request |
| poll_busy | output | 1 | High from the request until its acknowledge |

## Verification
The bench sets up four races and looks for the bad output each one would cause.

- A demand lands in the middle of a busy window. A design that fails to merge it gives a second request after the acknowledge.
- A stop pulse arrives while the timer is running. A timer that stop wrongly clears fires a few cycles early, not on the interval.
- A demand is issued between two periodic polls. If the design does not reload on a demanded poll, the next periodic request comes too soon.
- A demand is raised while tx_on is low. It must wait for tx_on to return. If a stop arrives first, it must vanish, and the poll-disable bit must survive that same stop. A leaky gate or a lost or kept demand shows up as an extra or a missing request.

// File: rtl/txpoll_pkg.sv
package txpoll_pkg;

   // Which condition wins the issue decision in a given cycle
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_TIMER  = 2'd1,
      SRC_DEMAND = 2'd2
   } poll_src_e;

endpackage

// File: rtl/txpoll_cfg.sv
module txpoll_cfg #(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned RST_INTERVAL = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             cfg_wr,
   input  logic             cfg_poll_dis,
   input  logic [CNT_W-1:0] cfg_interval,
   output logic             poll_dis,
   output logic [CNT_W-1:0] interval
);

   localparam logic [CNT_W-1:0] INTERVAL_RST = CNT_W'(RST_INTERVAL);

   logic             dis_q;
   logic [CNT_W-1:0] ivl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= 1'b0;
         ivl_q <= INTERVAL_RST;
      end else if (soft_rst) begin
         dis_q <= 1'b0;
         ivl_q <= INTERVAL_RST;
      end else if (cfg_wr) begin
         dis_q <= cfg_poll_dis;
         ivl_q <= cfg_interval;
      end
   end

   assign poll_dis = dis_q;
   assign interval = ivl_q;

   // R10: a write lands both fields at the next edge
   a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      cfg_wr |=> (poll_dis == $past(cfg_poll_dis)) && (interval == $past(cfg_interval)));

   // R10: without a write the configuration holds
   a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      !cfg_wr |=> $stable(poll_dis) && $stable(interval));

endmodule

// File: rtl/txpoll_timer.sv
module txpoll_timer #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned PRESCALE_W = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             reload,
   input  logic [CNT_W-1:0] interval_i,
   output logic             expired
);

   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   // Tick source: every clock, or once per 2**PRESCALE_W clocks
   generate
      if (PRESCALE_W == 0) begin : g_tick_direct
         assign tick = 1'b1;
      end else begin : g_tick_prescale
         logic [PRESCALE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        pre_q <= '0;
            else if (soft_rst) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
         assign tick = &pre_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= CNT_ZERO;
      else if (soft_rst)                cnt_q <= CNT_ZERO;
      else if (reload)                  cnt_q <= interval_i;
      else if (tick && cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
   end

   assign expired = (cnt_q == CNT_ZERO);

   // R7: every issued poll loads the programmed interval
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      reload |=> cnt_q == $past(interval_i));

   // R1: between reloads the count steps down by one per tick
   a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (!reload && tick && cnt_q != CNT_ZERO) |=> cnt_q == $past(cnt_q) - CNT_ONE);

   // R1: once expired and not reloaded, the timer rests at zero
   a_r1_rest: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (!reload && expired) |=> expired);

endmodule

// File: rtl/txpoll_arb.sv
module txpoll_arb
   import txpoll_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic stop,
   input  logic demand,
   input  logic tx_on,
   input  logic poll_dis,
   input  logic expired,
   input  logic poll_ack,
   output logic poll_req,
   output logic busy,
   output logic reload
);

   logic      dmd_q;
   logic      busy_q;
   logic      req_q;
   logic      accept;
   logic      issue;
   poll_src_e src;

   // Demand outranks the timer; both need the transmitter on and no poll outstanding
   always_comb begin
      src = SRC_NONE;
      if (tx_on && !busy_q) begin
         if (dmd_q || demand)           src = SRC_DEMAND;
         else if (expired && !poll_dis) src = SRC_TIMER;
      end
   end

   assign issue  = (src != SRC_NONE);
   assign accept = busy_q && poll_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dmd_q  <= 1'b0;
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else if (soft_rst) begin
         dmd_q  <= 1'b0;
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q <= issue;
         if (issue)       busy_q <= 1'b1;
         else if (accept) busy_q <= 1'b0;
         // acceptance clears the demand and absorbs any merged strobe
         if (accept)                   dmd_q <= 1'b0;
         else if (stop && !issue)      dmd_q <= 1'b0;
         else if (demand)              dmd_q <= 1'b1;
      end
   end

   assign poll_req = req_q;
   assign busy     = busy_q;
   assign reload   = issue;

   // R5: a request lasts one cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      poll_req |=> !poll_req);

   // R5: busy rises with the request
   a_r5_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      poll_req |-> busy);

   // R5: busy holds until acknowledged
   a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (busy && !poll_ack) |=> busy);

   // R4: no request unless the transmitter was on
   a_r4_txon_gate: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      poll_req |-> $past(tx_on));

   // R3: an eligible demand is served in the next cycle
   a_r3_demand_next: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (demand && tx_on && !busy) |=> poll_req);

   // R2: with polling disabled only a demand can start a request
   a_r2_no_periodic: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (poll_req && $past(poll_dis)) |-> $past(dmd_q || demand));

endmodule

// File: rtl/txpoll_sched.sv
module txpoll_sched #(
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned RST_INTERVAL = 1000,
   parameter int unsigned PRESCALE_W   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop,
   input  logic             cfg_wr,
   input  logic             cfg_poll_dis,
   input  logic [CNT_W-1:0] cfg_interval,
   input  logic             tx_demand,
   input  logic             tx_on,
   input  logic             poll_ack,
   output logic             poll_req,
   output logic             poll_busy
);

   localparam longint unsigned CNT_MAX = (64'd1 << CNT_W) - 64'd1;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("txpoll_sched: CNT_W must lie in 2..32");
      end
      if (longint'(RST_INTERVAL) > CNT_MAX) begin : g_bad_interval
         $error("txpoll_sched: RST_INTERVAL does not fit CNT_W bits");
      end
      if (PRESCALE_W > 16) begin : g_bad_prescale
         $error("txpoll_sched: PRESCALE_W must not exceed 16");
      end
   endgenerate

   logic             poll_dis;
   logic [CNT_W-1:0] interval;
   logic             expired;
   logic             reload;

   txpoll_cfg #(
      .CNT_W        (CNT_W),
      .RST_INTERVAL (RST_INTERVAL)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .cfg_wr       (cfg_wr),
      .cfg_poll_dis (cfg_poll_dis),
      .cfg_interval (cfg_interval),
      .poll_dis     (poll_dis),
      .interval     (interval)
   );

   txpoll_timer #(
      .CNT_W      (CNT_W),
      .PRESCALE_W (PRESCALE_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .reload     (reload),
      .interval_i (interval),
      .expired    (expired)
   );

   txpoll_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .stop     (stop),
      .demand   (tx_demand),
      .tx_on    (tx_on),
      .poll_dis (poll_dis),
      .expired  (expired),
      .poll_ack (poll_ack),
      .poll_req (poll_req),
      .busy     (poll_busy),
      .reload   (reload)
   );

   // R9: stop on its own leaves the disable bit in place
   a_r9_stop_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (stop && !cfg_wr) |=> $stable(poll_dis) && $stable(interval));

endmodule

// File: tb/txpoll_sched_tb.sv
module txpoll_sched_tb;

   localparam int CNT_W = 8;
   localparam int RST_IVL = 12;

   logic             clk = 1'b0;
   logic             rst_n, soft_rst, stop, cfg_wr, cfg_poll_dis;
   logic [CNT_W-1:0] cfg_interval;
   logic             tx_demand, tx_on, poll_ack, poll_req, poll_busy;
   logic             auto_ack, man_ack;

   int    cyc = 0;
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   assign poll_ack = (auto_ack & poll_req) | man_ack;

   txpoll_sched #(.CNT_W(CNT_W), .RST_INTERVAL(RST_IVL), .PRESCALE_W(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .cfg_wr(cfg_wr), .cfg_poll_dis(cfg_poll_dis), .cfg_interval(cfg_interval),
      .tx_demand(tx_demand), .tx_on(tx_on), .poll_ack(poll_ack),
      .poll_req(poll_req), .poll_busy(poll_busy));

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_req(input int at, input string tag);
      exp_q.push_back(at);
      tag_q.push_back(tag);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic cfg_write(input logic dis, input int ivl);
      cfg_wr = 1'b1; cfg_poll_dis = dis; cfg_interval = CNT_W'(ivl);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse_demand();
      tx_demand = 1'b1;
      @(negedge clk);
      tx_demand = 1'b0;
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            checks++; failures++;
            $display("FAIL %s: actual=no request expected=request at cycle %0d", tag_q[0], exp_q[0]);
            void'(exp_q.pop_front()); void'(tag_q.pop_front());
         end
         if (poll_req) begin
            checks++;
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
               void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end else begin
               failures++;
               $display("FAIL %s: actual=request at cycle %0d expected=%0d",
                        (tag_q.size() > 0) ? tag_q[0] : "R2/R5", cyc,
                        (exp_q.size() > 0) ? exp_q[0] : -1);
            end
         end
      end
   end

   initial begin
      repeat (6000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int c0, d, w, t, s, h;
      rst_n = 1'b0; soft_rst = 1'b0; stop = 1'b0; cfg_wr = 1'b0;
      cfg_poll_dis = 1'b0; cfg_interval = '0; tx_demand = 1'b0;
      tx_on = 1'b1; auto_ack = 1'b1; man_ack = 1'b0;
      repeat (3) @(negedge clk);
      check(int'(poll_req), 0, "R8 reset req");
      check(int'(poll_busy), 0, "R8 reset busy");

      // R8 first poll right after reset, then R1 period RST_IVL+1
      c0 = cyc;
      rst_n = 1'b1;
      expect_req(c0 + 1, "R8");
      expect_req(c0 + 14, "R1");
      expect_req(c0 + 27, "R1");
      wait_cyc(c0 + 27);
      cfg_write(1'b1, 5);               // R2, R10
      wait_cyc(c0 + 60);
      check(exp_q.size(), 0, "R2 no periodic while disabled");

      // R3 demand with polling disabled, R5 busy timing
      d = cyc;
      expect_req(d + 1, "R3");
      pulse_demand();
      check(int'(poll_busy), 1, "R5 busy with request");
      @(negedge clk);
      check(int'(poll_busy), 0, "R5 busy cleared by ack");

      // R5 busy hold and R6 merge of a demand during busy
      auto_ack = 1'b0;
      wait_cyc(cyc + 3);
      d = cyc;
      expect_req(d + 1, "R3");
      pulse_demand();
      wait_cyc(d + 3);
      pulse_demand();
      wait_cyc(d + 8);
      check(int'(poll_busy), 1, "R5 busy held without ack");
      wait_cyc(d + 10);
      man_ack = 1'b1;
      @(negedge clk);
      man_ack = 1'b0;
      check(int'(poll_busy), 0, "R5 busy dropped at ack");
      auto_ack = 1'b1;
      wait_cyc(d + 40);
      check(exp_q.size(), 0, "R6 merged demand gives no second poll");

      // R10 new config, R1 period 7, R7 demand restarts interval, R9 stop keeps timer
      w = cyc;
      cfg_write(1'b0, 6);
      expect_req(w + 2, "R10");
      expect_req(w + 9, "R1");
      wait_cyc(w + 12);
      expect_req(w + 13, "R7");
      expect_req(w + 20, "R7");
      expect_req(w + 27, "R1");
      pulse_demand();
      wait_cyc(w + 29);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      expect_req(w + 34, "R9");
      wait_cyc(w + 34);
      cfg_write(1'b1, 6);
      wait_cyc(w + 60);
      check(exp_q.size(), 0, "R2 periodic stops after disable");

      // R4 demand held while transmitter off
      t = cyc;
      tx_on = 1'b0;
      wait_cyc(t + 2);
      pulse_demand();
      wait_cyc(t + 10);
      check(int'(poll_busy), 0, "R4 no poll while off");
      tx_on = 1'b1;
      expect_req(t + 11, "R4");
      wait_cyc(t + 20);
      check(exp_q.size(), 0, "R4 pending demand served");

      // R9 stop drops a pending demand and keeps the disable bit
      s = cyc;
      tx_on = 1'b0;
      wait_cyc(s + 2);
      pulse_demand();
      wait_cyc(s + 4);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      wait_cyc(s + 6);
      tx_on = 1'b1;
      wait_cyc(s + 30);
      check(exp_q.size(), 0, "R9 stop discards demand");

      // R8 soft reset restores defaults, then hard reset mid-run
      h = cyc;
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      expect_req(h + 2, "R8");
      expect_req(h + 15, "R8");
      wait_cyc(h + 16);
      rst_n = 1'b0;
      @(negedge clk);
      check(int'(poll_busy), 0, "R8 hard reset busy");
      h = cyc;
      rst_n = 1'b1;
      expect_req(h + 1, "R8");
      wait_cyc(h + 5);
      check(exp_q.size(), 0, "R8 poll after hard reset");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule